// File: doc/BRIEF.md
# Dual Legacy Timer/Counter Pair

Two 16-bit timer/counters, each held as a low byte and a high byte, that keep the counting structures of the classic 8-bit controller timers. Each timer has its own structure select, clock source select, run bit and external gate option. A rollover sets a per-timer overflow flag. The flag is driven straight out as an interrupt request and is cleared either by an acknowledge pulse or by a register write.

Software reaches the block through a simple byte-wide write port. The count bytes, the run bits, the two configuration bytes and the flag register each sit at their own address. Count values and flags come back as plain outputs. Every clock source becomes a single-cycle count enable in the system clock domain, so all state lives on one clock.

Top module: `legacy_tmr_pair`

## Requirements
- R1: After reset both counts read 0x0000 and both bits of `irq_o` are low.
- R2: Structure code 0 (configuration bits [1:0]) counts 13 bits. Low-byte bits [4:0] form the least significant part and carry into the high byte. Low-byte bits [7:5] hold their value. The rollover from high byte 0xFF with low bits 0x1F clears both parts and signals an overflow.
- R3: Structure code 1 counts the full 16-bit value {high, low} by one per enabled tick, and signals an overflow when it wraps from 0xFFFF to 0x0000.
- R4: Structure code 2 counts the low byte only. When the low byte steps from 0xFF, it is loaded from the high byte and an overflow is signalled.
- R5: Structure code 3 on timer 0 splits it into two 8-bit counters. The low byte follows timer 0's run bit, gate and source, and sets flag 0. The high byte counts timer 0's selected tick under timer 1's run bit (no gate) and sets flag 1.
- R6: While timer 0 uses structure code 3, timer 1 holds its count. Structure code 3 on timer 1 alone also makes timer 1 hold.
- R7: An overflow sets the owning flag in the following cycle, and `irq_o[n]` is that flag. A set outranks a clear in the same cycle.
- R8: A flag clears one cycle after a pulse on `irq_ack_i[n]`, or it takes bit n of the data written to address 7.
- R9: Configuration bits [5:3] select the tick: 0 system clock, 1 every 4th cycle, 2 every 12th, 3 every 48th, 4 every 8th cycle in which `ext_clk_en_i` is high, and 5 the count pin. Codes 6 and 7 give no tick.
- R10: With source 5, the count pin passes through a two-stage synchronizer. Each falling edge advances the count by one.
- R11: A timer counts only while its run bit is set and either its gate option (configuration bit 2) is clear or its synchronized gate pin is high. Otherwise the count holds.
- R12: Write addresses: 0/1 are the timer 0 low/high bytes and 2/3 the timer 1 low/high bytes. Address 4 holds the run bits in bits [1:0], addresses 5/6 the timer 0/1 configuration, and address 7 the flags in bits [1:0]. A count-byte write takes effect at the next edge and outranks counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| ext_clk_en_i | input | 1 | One-cycle enable per external clock period |
| cnt_pin_i | input | 2 | Per-timer external count pin |
| gate_pin_i | input | 2 | Per-timer external gate pin |
| irq_ack_i | input | 2 | Per-timer interrupt acknowledge pulse |
| t0_cnt_o | output | 16 | Timer 0 count {high, low} |
| t1_cnt_o | output | 16 | Timer 1 count {high, low} |
| irq_o | output | 2 | Overflow flags / interrupt requests |

## Verification
Each structure is driven from a preloaded value just short of its rollover. This separates a 13-bit carry (which leaves low-byte bits [7:5] alone) from a 16-bit wrap and from an 8-bit reload out of the high byte. The split structure is run with the two run bits set one at a time, which shows that each half has its own run bit and flag and that timer 1 is frozen. The divided sources are run for windows that are whole multiples of 48 cycles, so the tick count is exact whatever the divider phase. The pin and gate patterns tell falling-edge counting apart from level counting, and a gated hold apart from a run hold.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13B    = 2'd0,
    MODE_16B    = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmr_mode_e;

  localparam logic [2:0] SRC_SYS   = 3'd0;
  localparam logic [2:0] SRC_DIV_A = 3'd1;
  localparam logic [2:0] SRC_DIV_B = 3'd2;
  localparam logic [2:0] SRC_DIV_C = 3'd3;
  localparam logic [2:0] SRC_EXT   = 3'd4;
  localparam logic [2:0] SRC_PIN   = 3'd5;

  typedef struct packed {
    logic [2:0] src;
    logic       gate;
    tmr_mode_e  mode;
  } tmr_cfg_t;

  localparam logic [2:0] ADDR_T0_LO = 3'd0;
  localparam logic [2:0] ADDR_RUN   = 3'd4;
  localparam logic [2:0] ADDR_CFG0  = 3'd5;
  localparam logic [2:0] ADDR_FLAG  = 3'd7;
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(DIV - 1));
  assign tick_o = en_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= last ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign fall_o  = prev_q & ~s2_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0,
  parameter int BYTE_W   = 8,
  parameter int LOW_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              step_lo_i,
  input  logic              step_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_lo_o,
  output logic              ovf_hi_o
);
  localparam int WW = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic              split_ok;

  if (SPLIT_OK) begin : g_split
    assign split_ok = 1'b1;
  end else begin : g_nosplit
    assign split_ok = 1'b0;
  end

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_lo_o = 1'b0;
    ovf_hi_o = 1'b0;
    unique case (mode_i)
      MODE_13B: if (step_lo_i) begin
        if (&lo_q[LOW_W-1:0]) begin
          lo_n[LOW_W-1:0] = '0;
          hi_n            = hi_q + BYTE_W'(1);
          ovf_lo_o        = &hi_q;
        end else begin
          lo_n[LOW_W-1:0] = lo_q[LOW_W-1:0] + LOW_W'(1);
        end
      end
      MODE_16B: if (step_lo_i) begin
        {hi_n, lo_n} = {hi_q, lo_q} + WW'(1);
        ovf_lo_o     = &{hi_q, lo_q};
      end
      MODE_RELOAD: if (step_lo_i) begin
        if (&lo_q) begin
          lo_n     = hi_q;
          ovf_lo_o = 1'b1;
        end else begin
          lo_n = lo_q + BYTE_W'(1);
        end
      end
      MODE_SPLIT: if (split_ok) begin
        if (step_lo_i) begin
          lo_n     = lo_q + BYTE_W'(1);
          ovf_lo_o = &lo_q;
        end
        if (step_hi_i) begin
          hi_n     = hi_q + BYTE_W'(1);
          ovf_hi_o = &hi_q;
        end
      end
      default: ;
    endcase
    if (wr_lo_i) lo_n = wr_data_i;
    if (wr_hi_i) hi_n = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/legacy_tmr_pair.sv
module legacy_tmr_pair
  import tmr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int LOW_W   = 5,
  parameter int DIV_A   = 4,
  parameter int DIV_B   = 12,
  parameter int DIV_C   = 48,
  parameter int EXT_DIV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ext_clk_en_i,
  input  logic [1:0]        cnt_pin_i,
  input  logic [1:0]        gate_pin_i,
  input  logic [1:0]        irq_ack_i,
  output logic [2*BYTE_W-1:0] t0_cnt_o,
  output logic [2*BYTE_W-1:0] t1_cnt_o,
  output logic [1:0]        irq_o
);
  localparam int NT = 2;
  localparam int ND = 3;
  localparam int DIV_TAB [ND] = '{DIV_A, DIV_B, DIV_C};

  logic [NT-1:0] run_q, flag_q, flag_n, set_flag;
  tmr_cfg_t      cfg_q [NT];
  logic [ND-1:0] tick_div;
  logic          tick_ext;
  logic [NT-1:0] pin_fall, gate_lvl, tick_sel, allowed;
  logic [NT-1:0] step_lo, step_hi, wr_lo, wr_hi, ovf_lo, ovf_hi;
  logic [BYTE_W-1:0] lo_w [NT];
  logic [BYTE_W-1:0] hi_w [NT];
  logic          split;

  for (genvar d = 0; d < ND; d++) begin : g_div
    tmr_divider #(.DIV(DIV_TAB[d])) u_div (
      .clk_i, .rst_ni, .en_i(1'b1), .tick_o(tick_div[d])
    );
  end

  tmr_divider #(.DIV(EXT_DIV)) u_ext_div (
    .clk_i, .rst_ni, .en_i(ext_clk_en_i), .tick_o(tick_ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_RUN) run_q <= wr_data_i[NT-1:0];
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    tmr_sync_edge u_cnt_sync (
      .clk_i, .rst_ni, .pin_i(cnt_pin_i[t]), .level_o(), .fall_o(pin_fall[t])
    );
    tmr_sync_edge u_gate_sync (
      .clk_i, .rst_ni, .pin_i(gate_pin_i[t]), .level_o(gate_lvl[t]), .fall_o()
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[t] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_CFG0 + 3'(t))
        cfg_q[t] <= tmr_cfg_t'(wr_data_i[5:0]);
    end

    always_comb begin
      unique case (cfg_q[t].src)
        SRC_SYS:   tick_sel[t] = 1'b1;
        SRC_DIV_A: tick_sel[t] = tick_div[0];
        SRC_DIV_B: tick_sel[t] = tick_div[1];
        SRC_DIV_C: tick_sel[t] = tick_div[2];
        SRC_EXT:   tick_sel[t] = tick_ext;
        SRC_PIN:   tick_sel[t] = pin_fall[t];
        default:   tick_sel[t] = 1'b0;
      endcase
    end

    assign allowed[t] = run_q[t] & (~cfg_q[t].gate | gate_lvl[t]);
    assign wr_lo[t]   = wr_en_i && wr_addr_i == ADDR_T0_LO + 3'(2 * t);
    assign wr_hi[t]   = wr_en_i && wr_addr_i == ADDR_T0_LO + 3'(2 * t + 1);

    tmr_core #(.SPLIT_OK(t == 0), .BYTE_W(BYTE_W), .LOW_W(LOW_W)) u_core (
      .clk_i, .rst_ni,
      .mode_i    (cfg_q[t].mode),
      .step_lo_i (step_lo[t]),
      .step_hi_i (step_hi[t]),
      .wr_lo_i   (wr_lo[t]),
      .wr_hi_i   (wr_hi[t]),
      .wr_data_i,
      .lo_o      (lo_w[t]),
      .hi_o      (hi_w[t]),
      .ovf_lo_o  (ovf_lo[t]),
      .ovf_hi_o  (ovf_hi[t])
    );
  end

  // timer 0 split lends its high half to timer 1's run bit and flag
  assign split      = (cfg_q[0].mode == MODE_SPLIT);
  assign step_lo[0] = tick_sel[0] & allowed[0];
  assign step_hi[0] = tick_sel[0] & run_q[1];
  assign step_lo[1] = tick_sel[1] & allowed[1] & ~split;
  assign step_hi[1] = 1'b0;

  assign set_flag[0] = ovf_lo[0];
  assign set_flag[1] = ovf_hi[0] | ovf_lo[1];

  always_comb begin
    if (wr_en_i && wr_addr_i == ADDR_FLAG) flag_n = wr_data_i[NT-1:0];
    else                                   flag_n = flag_q & ~irq_ack_i;
    flag_n = flag_n | set_flag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_n;
  end

  assign t0_cnt_o = {hi_w[0], lo_w[0]};
  assign t1_cnt_o = {hi_w[1], lo_w[1]};
  assign irq_o    = flag_q;
endmodule

// File: rtl/legacy_tmr_pair_chk.sv
module legacy_tmr_pair_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_addr_i,
  input logic [1:0]       irq_ack_i,
  input logic [1:0]       irq_o,
  input logic [CNT_W-1:0] t1_cnt_o,
  input logic [1:0]       set_flag,
  input logic [1:0]       run_q,
  input logic             t1_step,
  input tmr_mode_e        t1_mode,
  input logic             split
);
  AST_FLAG0_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flag[0] |=> irq_o[0]); // R7
  AST_FLAG1_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flag[1] |=> irq_o[1]); // R7
  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i[0] && !set_flag[0] && !(wr_en_i && wr_addr_i == ADDR_FLAG)) |=> !irq_o[0]); // R8
  AST_WIDE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1_step && t1_mode == MODE_16B && !wr_en_i) |=> t1_cnt_o == $past(t1_cnt_o) + CNT_W'(1)); // R3
  AST_SPLIT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split && !wr_en_i) |=> $stable(t1_cnt_o)); // R6
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q[1] && !wr_en_i) |=> $stable(t1_cnt_o)); // R11
endmodule

bind legacy_tmr_pair legacy_tmr_pair_chk #(.CNT_W(2 * BYTE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .irq_ack_i (irq_ack_i),
  .irq_o     (irq_o),
  .t1_cnt_o  (t1_cnt_o),
  .set_flag  (set_flag),
  .run_q     (run_q),
  .t1_step   (step_lo[1]),
  .t1_mode   (cfg_q[1].mode),
  .split     (split)
);

// File: tb/legacy_tmr_pair_test.sv
module legacy_tmr_pair_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        ext_clk_en_i = 1'b0;
  logic [1:0]  cnt_pin_i = 2'b11;
  logic [1:0]  gate_pin_i = 2'b00;
  logic [1:0]  irq_ack_i = 2'b00;
  logic [15:0] t0_cnt_o, t1_cnt_o;
  logic [1:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  legacy_tmr_pair uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic load(input int t, input logic [15:0] v);
    wr(3'(2 * t), v[7:0]);
    wr(3'(2 * t + 1), v[15:8]);
  endtask

  task automatic run_n(input logic [1:0] mask, input int n);
    wr(3'd4, {6'd0, mask});
    repeat (n - 1) @(negedge clk_i);
    wr(3'd4, 8'd0);
  endtask

  task automatic t_reset;
    chk("R1 t0", t0_cnt_o, 16'h0000);
    chk("R1 t1", t1_cnt_o, 16'h0000);
    chk("R1 irq", {14'd0, irq_o}, 16'h0000);
  endtask

  task automatic t_mode1;
    wr(3'd6, 8'h01);
    load(1, 16'hFFFE);
    chk("R12 load", t1_cnt_o, 16'hFFFE);
    run_n(2'b10, 3);
    chk("R3 wrap", t1_cnt_o, 16'h0001);
    chk("R7 flag", {14'd0, irq_o}, 16'h0002);
    irq_ack_i = 2'b10;
    @(negedge clk_i);
    irq_ack_i = 2'b00;
    chk("R8 ack", {14'd0, irq_o}, 16'h0000);
    load(1, 16'hFFFF);
    run_n(2'b10, 1);
    chk("R7 reflag", {14'd0, irq_o}, 16'h0002);
    wr(3'd7, 8'h00);
    chk("R8 sw clear", {14'd0, irq_o}, 16'h0000);
  endtask

  task automatic t_mode0;
    wr(3'd5, 8'h00);
    load(0, 16'hFFBE);
    run_n(2'b01, 2);
    chk("R2 wrap", t0_cnt_o, 16'h00A0);
    chk("R2 flag", {14'd0, irq_o}, 16'h0001);
    wr(3'd7, 8'h00);
    load(0, 16'h121F);
    run_n(2'b01, 1);
    chk("R2 carry", t0_cnt_o, 16'h1300);
    chk("R2 noflag", {14'd0, irq_o}, 16'h0000);
  endtask

  task automatic t_mode2;
    wr(3'd6, 8'h02);
    load(1, 16'h80FE);
    run_n(2'b10, 4);
    chk("R4 reload", t1_cnt_o, 16'h8082);
    chk("R4 flag", {14'd0, irq_o}, 16'h0002);
    wr(3'd7, 8'h00);
  endtask

  task automatic t_presc;
    wr(3'd6, 8'h09);
    load(1, 16'h0000);
    run_n(2'b10, 48);
    chk("R9 div4", t1_cnt_o, 16'd12);
    wr(3'd6, 8'h11);
    load(1, 16'h0000);
    run_n(2'b10, 48);
    chk("R9 div12", t1_cnt_o, 16'd4);
    wr(3'd6, 8'h19);
    load(1, 16'h0000);
    run_n(2'b10, 48);
    chk("R9 div48", t1_cnt_o, 16'd1);
    wr(3'd6, 8'h21);
    load(1, 16'h0000);
    ext_clk_en_i = 1'b1;
    run_n(2'b10, 48);
    ext_clk_en_i = 1'b0;
    chk("R9 ext8", t1_cnt_o, 16'd6);
  endtask

  task automatic t_pin;
    wr(3'd5, 8'h29);
    load(0, 16'h0000);
    wr(3'd4, 8'h01);
    for (int i = 0; i < 5; i++) begin
      cnt_pin_i[0] = 1'b0;
      repeat (4) @(negedge clk_i);
      cnt_pin_i[0] = 1'b1;
      repeat (4) @(negedge clk_i);
    end
    wr(3'd4, 8'h00);
    chk("R10 edges", t0_cnt_o, 16'd5);
  endtask

  task automatic t_gate;
    wr(3'd6, 8'h05);
    load(1, 16'h0000);
    gate_pin_i[1] = 1'b0;
    repeat (4) @(negedge clk_i);
    run_n(2'b10, 10);
    chk("R11 gated", t1_cnt_o, 16'd0);
    gate_pin_i[1] = 1'b1;
    repeat (4) @(negedge clk_i);
    run_n(2'b10, 10);
    chk("R11 open", t1_cnt_o, 16'd10);
    gate_pin_i[1] = 1'b0;
  endtask

  task automatic t_split;
    wr(3'd6, 8'h01);
    load(1, 16'h1234);
    wr(3'd5, 8'h03);
    load(0, 16'hFEFF);
    wr(3'd7, 8'h00);
    run_n(2'b01, 1);
    chk("R5 low half", t0_cnt_o, 16'hFE00);
    chk("R5 flag0", {14'd0, irq_o}, 16'h0001);
    wr(3'd7, 8'h00);
    run_n(2'b10, 2);
    chk("R5 high half", t0_cnt_o, 16'h0000);
    chk("R5 flag1", {14'd0, irq_o}, 16'h0002);
    chk("R6 t1 frozen", t1_cnt_o, 16'h1234);
    wr(3'd7, 8'h00);
    wr(3'd5, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mode1();
    t_mode0();
    t_mode2();
    t_presc();
    t_pin();
    t_gate();
    t_split();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule